// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block drives a serial flash over a four-wire SPI link (mode 0, most significant bit first) in response to a single write of a command-control word. The write selects a command from an eight-entry opcode menu through a 3-bit pointer. It also says whether a data phase follows and how long that phase is, and whether the command is wrapped in an atomic sequence. Each menu entry carries a two-bit type that tells the sequencer whether a 24-bit address follows the opcode and which way the data moves.

In atomic mode the sequencer runs three commands on its own. The first is a lone write-enable prefix byte, taken from one of two prefix opcodes. The second is the selected main command. The third is Read Status (05h), repeated until the flash reports that it is no longer busy. Chip select returns high between these commands. A second requester that wants the flash gets no grant while such a sequence runs. The block keeps an in-progress flag and a done flag, and it raises an interrupt request from the done flag when that is enabled. The serial clock rate is set by a 3-bit code, which a lock-down input can freeze.

Top module: `spi_cmd_seq`

## Requirements
- R1: The data phase moves byte-count + 1 bytes: a count field of 0 moves one byte and 63 moves sixty-four. On writes, byte k comes from `wdata[8k+7:8k]`.
- R2: With the data-enable bit at 0, the command ends after its opcode, plus its address if it has one. The byte count is ignored in that case.
- R3: An atomic command sends three kinds of frame in this order: the prefix byte alone, then the main command, then frames of 05h followed by one status byte. Status frames repeat while status bit 0 reads 1. Chip select goes high between frames.
- R4: Through an atomic sequence, `cyc_busy` stays 1 and `cyc_done` stays 0 until a polled status byte has bit 0 clear. Then `cyc_busy` falls and `cyc_done` rises in the same cycle.
- R5: A control write with `ctl_go` set, made while idle, sets `cyc_busy` from the next cycle and clears `cyc_done`.
- R6: A control write made while `cyc_busy` is 1 starts nothing and leaves the running command's fields unchanged. Only the interrupt enable follows such a write.
- R7: The fields written in the same access as `ctl_go` = 1 govern the cycle that access starts.
- R8: `ctl_prefix_sel` = 0 sends `prefix_opcodes[7:0]` as the prefix, and 1 sends `prefix_opcodes[15:8]`.
- R9: Rate code 000 selects a serial clock half-period of `HALF_SLOW` system clocks, 001 selects `HALF_MID` and 100 selects `HALF_FAST`. Any other code falls back to `HALF_SLOW`. A command whose menu type is 01 (address, read) always uses `HALF_SLOW`. `cur_rate` reads back the stored code.
- R10: While `lock_down` is 1, control writes do not change the stored rate code.
- R11: `irq` equals `cyc_done` AND the stored interrupt enable. A one-cycle pulse on `done_clr` clears `cyc_done`.
- R12: `gnt2` follows `req2`, except that it is 0 while an atomic sequence runs. It is also 0 in the cycle of the control write that starts such a sequence.
- R13: Menu type bit 0 adds three address bytes, most significant first. Bit 1 set means write data, clear means read data: zero bytes are sent and received byte k is stored in `rdata[8k+7:8k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | One-cycle strobe for a control-word write |
| ctl_go | input | 1 | Start bit of the control write |
| ctl_atomic | input | 1 | Run the write as an atomic sequence |
| ctl_prefix_sel | input | 1 | Chooses one of the two prefix opcodes |
| ctl_op_ptr | input | PTR_W | Opcode menu index |
| ctl_data_en | input | 1 | Command has a data phase |
| ctl_byte_cnt | input | CNT_W | Data bytes minus one |
| ctl_irq_en | input | 1 | Interrupt enable |
| ctl_rate | input | 3 | Serial clock rate code |
| lock_down | input | 1 | Freezes the rate code |
| done_clr | input | 1 | Clears the done flag |
| menu_opcodes | input | 8*MENU_N | Opcode menu, entry i in bits 8i+7:8i |
| menu_types | input | 2*MENU_N | Entry types: bit 0 address, bit 1 write |
| prefix_opcodes | input | 16 | Two prefix opcodes |
| addr | input | 24 | Flash address, taken at start |
| wdata | input | 8*MAX_BYTES | Write data buffer |
| rdata | output | 8*MAX_BYTES | Read data buffer |
| cyc_busy | output | 1 | Cycle in progress |
| cyc_done | output | 1 | Cycle done |
| irq | output | 1 | Interrupt request |
| cur_rate | output | 3 | Stored rate code |
| req2 | input | 1 | Second requester asks for the flash |
| gnt2 | output | 1 | Grant to the second requester |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The start of an atomic sequence and a request from the second requester can land in the same cycle. The grant is combinational on `req2`, while the lock flag only becomes a register one cycle later. The bench holds `req2` high, drives the starting control write, and reads `gnt2` just after the inputs settle, before the edge that records the start. `gnt2` must already be 0 then, and it must stay 0 until the done flag rises. A second overlap comes from a go write that arrives while status polling is under way. The scoreboard holds exactly the frames the atomic command should produce, so an extra command frame caused by that write shows up as a byte mismatch.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PFX,
        ST_CMD,
        ST_ADR,
        ST_DAT,
        ST_GAP,
        ST_POLL_OP,
        ST_POLL_RD
    } seq_st_e;

    localparam logic [7:0] RDSR_OP   = 8'h05;
    localparam logic [2:0] RATE_SLOW = 3'b000;
    localparam logic [2:0] RATE_MID  = 3'b001;
    localparam logic [2:0] RATE_FAST = 3'b100;

endpackage

// File: rtl/spi_seq_rate.sv
module spi_seq_rate #(
    parameter int HALF_W    = 8,
    parameter int HALF_SLOW = 5,
    parameter int HALF_MID  = 3,
    parameter int HALF_FAST = 2
) (
    input  logic [2:0]        rate_code,
    input  logic              force_slow,
    output logic [HALF_W-1:0] half
);
    import spi_seq_pkg::*;

    always_comb begin
        half = HALF_W'(HALF_SLOW);
        if (!force_slow) begin
            case (rate_code)
                RATE_MID:  half = HALF_W'(HALF_MID);
                RATE_FAST: half = HALF_W'(HALF_FAST);
                default:   half = HALF_W'(HALF_SLOW);
            endcase
        end
    end
endmodule

// File: rtl/spi_seq_shift.sv
module spi_seq_shift #(
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        tx_byte,
    input  logic [HALF_W-1:0] half,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic [7:0]        rx_byte,
    output logic              done
);
    typedef struct packed {
        logic              busy;
        logic              sck;
        logic [2:0]        bitn;
        logic [HALF_W-1:0] cnt;
        logic [7:0]        tx;
        logic [7:0]        rx;
        logic              done;
    } sh_t;

    sh_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (start) begin
            d.busy = 1'b1;
            d.sck  = 1'b0;
            d.bitn = '0;
            d.cnt  = '0;
            d.tx   = tx_byte;
        end else if (q.busy) begin
            if (q.cnt == half - 1'b1) begin
                d.cnt = '0;
                if (!q.sck) begin
                    d.sck = 1'b1;
                    d.rx  = {q.rx[6:0], miso};
                end else begin
                    d.sck = 1'b0;
                    if (q.bitn == 3'd7) begin
                        d.busy = 1'b0;
                        d.done = 1'b1;
                    end else begin
                        d.bitn = q.bitn + 3'd1;
                        d.tx   = {q.tx[6:0], 1'b0};
                    end
                end
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sck     = q.sck;
    assign mosi    = q.tx[7];
    assign rx_byte = q.rx;
    assign done    = q.done;
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq #(
    parameter int MENU_N    = 8,
    parameter int MAX_BYTES = 64,
    parameter int HALF_W    = 8,
    parameter int HALF_SLOW = 5,
    parameter int HALF_MID  = 3,
    parameter int HALF_FAST = 2,
    parameter int GAP_CYC   = 2,
    localparam int PTR_W    = $clog2(MENU_N),
    localparam int CNT_W    = $clog2(MAX_BYTES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ctl_wr,
    input  logic                   ctl_go,
    input  logic                   ctl_atomic,
    input  logic                   ctl_prefix_sel,
    input  logic [PTR_W-1:0]       ctl_op_ptr,
    input  logic                   ctl_data_en,
    input  logic [CNT_W-1:0]       ctl_byte_cnt,
    input  logic                   ctl_irq_en,
    input  logic [2:0]             ctl_rate,
    input  logic                   lock_down,
    input  logic                   done_clr,
    input  logic [8*MENU_N-1:0]    menu_opcodes,
    input  logic [2*MENU_N-1:0]    menu_types,
    input  logic [15:0]            prefix_opcodes,
    input  logic [23:0]            addr,
    input  logic [8*MAX_BYTES-1:0] wdata,
    output logic [8*MAX_BYTES-1:0] rdata,
    output logic                   cyc_busy,
    output logic                   cyc_done,
    output logic                   irq,
    output logic [2:0]             cur_rate,
    input  logic                   req2,
    output logic                   gnt2,
    output logic                   spi_sck,
    output logic                   spi_cs_n,
    output logic                   spi_mosi,
    input  logic                   spi_miso
);
    import spi_seq_pkg::*;

    localparam int GW = $clog2(GAP_CYC + 1);

    typedef struct packed {
        seq_st_e                st;
        seq_st_e                ret;
        logic [CNT_W-1:0]       idx;
        logic [GW-1:0]          gap;
        logic                   cs_n;
        logic                   start;
        logic [7:0]             tx;
        logic                   busy;
        logic                   done;
        logic                   lock;
        logic                   atomic;
        logic                   psel;
        logic [PTR_W-1:0]       ptr;
        logic                   den;
        logic [CNT_W-1:0]       cnt;
        logic                   irq_en;
        logic [2:0]             rate;
        logic [23:0]            addr;
        logic [8*MAX_BYTES-1:0] rbuf;
    } seq_t;

    seq_t q, d;

    logic [7:0]        cur_op;
    logic [1:0]        cur_type;
    logic [HALF_W-1:0] half;
    logic              sh_done;
    logic [7:0]        sh_rx;
    logic              go_data, go_end, go_fin;
    logic [CNT_W-1:0]  nxt;
    logic              atomic_start;

    assign cur_op       = menu_opcodes[int'(q.ptr)*8 +: 8];
    assign cur_type     = menu_types[int'(q.ptr)*2 +: 2];
    assign nxt          = q.idx + 1'b1;
    assign atomic_start = ctl_wr & ctl_go & ctl_atomic & ~q.busy;

    spi_seq_rate #(
        .HALF_W(HALF_W), .HALF_SLOW(HALF_SLOW),
        .HALF_MID(HALF_MID), .HALF_FAST(HALF_FAST)
    ) u_rate (
        .rate_code (q.rate),
        .force_slow(cur_type == 2'b01),
        .half      (half)
    );

    spi_seq_shift #(.HALF_W(HALF_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (q.start),
        .tx_byte(q.tx),
        .half   (half),
        .miso   (spi_miso),
        .sck    (spi_sck),
        .mosi   (spi_mosi),
        .rx_byte(sh_rx),
        .done   (sh_done)
    );

    always_comb begin
        d       = q;
        d.start = 1'b0;
        go_data = 1'b0;
        go_end  = 1'b0;
        go_fin  = 1'b0;
        if (done_clr) d.done = 1'b0;

        if (ctl_wr) begin
            d.irq_en = ctl_irq_en;
            if (!q.busy) begin
                d.atomic = ctl_atomic;
                d.psel   = ctl_prefix_sel;
                d.ptr    = ctl_op_ptr;
                d.den    = ctl_data_en;
                d.cnt    = ctl_byte_cnt;
                if (!lock_down) d.rate = ctl_rate;
                if (ctl_go) begin
                    d.busy  = 1'b1;
                    d.done  = 1'b0;
                    d.lock  = ctl_atomic;
                    d.addr  = addr;
                    d.cs_n  = 1'b0;
                    d.start = 1'b1;
                    d.idx   = '0;
                    if (ctl_atomic) begin
                        d.st = ST_PFX;
                        d.tx = ctl_prefix_sel ? prefix_opcodes[15:8] : prefix_opcodes[7:0];
                    end else begin
                        d.st = ST_CMD;
                        d.tx = menu_opcodes[int'(ctl_op_ptr)*8 +: 8];
                    end
                end
            end
        end

        case (q.st)
            ST_GAP: begin
                if (q.gap == '0) begin
                    d.st    = q.ret;
                    d.cs_n  = 1'b0;
                    d.start = 1'b1;
                    d.tx    = (q.ret == ST_CMD) ? cur_op : RDSR_OP;
                end else begin
                    d.gap = q.gap - 1'b1;
                end
            end
            ST_PFX: if (sh_done) begin
                d.cs_n = 1'b1;
                d.st   = ST_GAP;
                d.ret  = ST_CMD;
                d.gap  = GW'(GAP_CYC - 1);
            end
            ST_CMD: if (sh_done) begin
                if (cur_type[0]) begin
                    d.st    = ST_ADR;
                    d.idx   = '0;
                    d.start = 1'b1;
                    d.tx    = q.addr[23:16];
                end else if (q.den) begin
                    go_data = 1'b1;
                end else begin
                    go_end = 1'b1;
                end
            end
            ST_ADR: if (sh_done) begin
                if (q.idx == CNT_W'(2)) begin
                    if (q.den) go_data = 1'b1;
                    else       go_end  = 1'b1;
                end else begin
                    d.idx   = nxt;
                    d.start = 1'b1;
                    d.tx    = (q.idx == '0) ? q.addr[15:8] : q.addr[7:0];
                end
            end
            ST_DAT: if (sh_done) begin
                if (!cur_type[1]) d.rbuf[int'(q.idx)*8 +: 8] = sh_rx;
                if (q.idx == q.cnt) begin
                    go_end = 1'b1;
                end else begin
                    d.idx   = nxt;
                    d.start = 1'b1;
                    d.tx    = cur_type[1] ? wdata[int'(nxt)*8 +: 8] : 8'h00;
                end
            end
            ST_POLL_OP: if (sh_done) begin
                d.st    = ST_POLL_RD;
                d.start = 1'b1;
                d.tx    = 8'h00;
            end
            ST_POLL_RD: if (sh_done) begin
                d.cs_n = 1'b1;
                if (sh_rx[0]) begin
                    d.st  = ST_GAP;
                    d.ret = ST_POLL_OP;
                    d.gap = GW'(GAP_CYC - 1);
                end else begin
                    go_fin = 1'b1;
                end
            end
            default: ;
        endcase

        if (go_data) begin
            d.st    = ST_DAT;
            d.idx   = '0;
            d.start = 1'b1;
            d.tx    = cur_type[1] ? wdata[7:0] : 8'h00;
        end
        if (go_end) begin
            d.cs_n = 1'b1;
            if (q.atomic) begin
                d.st  = ST_GAP;
                d.ret = ST_POLL_OP;
                d.gap = GW'(GAP_CYC - 1);
            end else begin
                go_fin = 1'b1;
            end
        end
        if (go_fin) begin
            d.st   = ST_IDLE;
            d.busy = 1'b0;
            d.done = 1'b1;
            d.lock = 1'b0;
            d.cs_n = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.ret  <= ST_IDLE;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rdata    = q.rbuf;
    assign cyc_busy = q.busy;
    assign cyc_done = q.done;
    assign irq      = q.done & q.irq_en;
    assign cur_rate = q.rate;
    assign spi_cs_n = q.cs_n;
    assign gnt2     = req2 & ~q.lock & ~atomic_start;
endmodule

// File: rtl/spi_cmd_seq_chk.sv
module spi_cmd_seq_chk #(
    parameter int PTR_W = 3,
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_wr,
    input logic             ctl_go,
    input logic             lock_down,
    input logic             cyc_busy,
    input logic             cyc_done,
    input logic             irq,
    input logic [2:0]       cur_rate,
    input logic             gnt2,
    input logic             spi_cs_n,
    input logic             atomic_q,
    input logic [PTR_W-1:0] ptr_q,
    input logic [CNT_W-1:0] cnt_q
);
    AST_GO_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_go && !cyc_busy) |=> cyc_busy); // R5
    AST_BUSY_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && cyc_busy) |=> ($stable(ptr_q) && $stable(cnt_q))); // R6
    AST_DONE_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cyc_done) |-> ($past(cyc_busy) && !cyc_busy)); // R4
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> cyc_done); // R11
    AST_CS_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_busy |-> spi_cs_n); // R3
    AST_RATE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        lock_down |=> $stable(cur_rate)); // R10
    AST_ATOMIC_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_busy && atomic_q) |-> !gnt2); // R12
endmodule

bind spi_cmd_seq spi_cmd_seq_chk #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_wr   (ctl_wr),
    .ctl_go   (ctl_go),
    .lock_down(lock_down),
    .cyc_busy (cyc_busy),
    .cyc_done (cyc_done),
    .irq      (irq),
    .cur_rate (cur_rate),
    .gnt2     (gnt2),
    .spi_cs_n (spi_cs_n),
    .atomic_q (q.atomic),
    .ptr_q    (q.ptr),
    .cnt_q    (q.cnt)
);

// File: tb/spi_cmd_seq_test.sv
module spi_cmd_seq_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_wr = 0, ctl_go = 0, ctl_atomic = 0, ctl_prefix_sel = 0;
    logic [2:0] ctl_op_ptr = 0;
    logic ctl_data_en = 0;
    logic [5:0] ctl_byte_cnt = 0;
    logic ctl_irq_en = 0;
    logic [2:0] ctl_rate = 0;
    logic lock_down = 0, done_clr = 0, req2 = 0;
    logic [63:0] menu_opcodes;
    logic [15:0] menu_types;
    logic [15:0] prefix_opcodes = 16'h5006;
    logic [23:0] addr = 24'h123456;
    logic [511:0] wdata;
    logic [511:0] rdata;
    logic cyc_busy, cyc_done, irq, gnt2, spi_sck, spi_cs_n, spi_mosi;
    logic spi_miso = 1'b0;
    logic [2:0] cur_rate;

    always #4 clk = ~clk;

    spi_cmd_seq uut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_go(ctl_go),
        .ctl_atomic(ctl_atomic), .ctl_prefix_sel(ctl_prefix_sel),
        .ctl_op_ptr(ctl_op_ptr), .ctl_data_en(ctl_data_en),
        .ctl_byte_cnt(ctl_byte_cnt), .ctl_irq_en(ctl_irq_en),
        .ctl_rate(ctl_rate), .lock_down(lock_down), .done_clr(done_clr),
        .menu_opcodes(menu_opcodes), .menu_types(menu_types),
        .prefix_opcodes(prefix_opcodes), .addr(addr), .wdata(wdata),
        .rdata(rdata), .cyc_busy(cyc_busy), .cyc_done(cyc_done), .irq(irq),
        .cur_rate(cur_rate), .req2(req2), .gnt2(gnt2), .spi_sck(spi_sck),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int n_chk = 0, n_bad = 0, mon_cmp = 0, mon_bad = 0;
    string cur_req = "R0";
    logic [8:0] exp_q[$];
    logic armed = 1'b0;
    int busy_polls = 0;
    int polls = 0;
    int last_hi = 0;

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_b(input logic [7:0] b); exp_q.push_back({1'b0, b}); endtask
    task automatic push_end(); exp_q.push_back(9'h100); endtask

    // Flash model and scoreboard monitor
    logic p_sck = 1'b0, p_cs = 1'b1;
    int bitc = 0, byte_i = 0;
    logic [7:0] shreg = 0, resp = 0, fb = 0;
    realtime t_rise = 0;
    always @(spi_sck or spi_cs_n) begin
        if (armed) begin
            if (spi_cs_n !== p_cs) begin
                if (!spi_cs_n) begin
                    bitc = 0; byte_i = 0; spi_miso = 1'b0;
                end else begin
                    logic [8:0] e;
                    e = (exp_q.size() > 0) ? exp_q.pop_front() : 9'h1FF;
                    mon_cmp++;
                    if (e !== 9'h100) begin
                        mon_bad++;
                        $display("FAIL %s frame end actual=100 expected=%0h", cur_req, e);
                    end
                    if (fb == 8'h05) polls++;
                end
            end else if (spi_sck && !p_sck) begin
                t_rise = $realtime;
                shreg = {shreg[6:0], spi_mosi};
                bitc++;
                if (bitc == 8) begin
                    logic [8:0] e;
                    bitc = 0;
                    if (byte_i == 0) fb = shreg;
                    e = (exp_q.size() > 0) ? exp_q.pop_front() : 9'h1FF;
                    mon_cmp++;
                    if (e !== {1'b0, shreg}) begin
                        mon_bad++;
                        $display("FAIL %s byte %0d actual=%0h expected=%0h", cur_req, byte_i, shreg, e);
                    end
                    byte_i++;
                    if (fb == 8'h05) resp = (polls < busy_polls) ? 8'h03 : 8'h02;
                    else             resp = 8'h40 + 8'(byte_i);
                end
            end else if (!spi_sck && p_sck) begin
                last_hi = int'(($realtime - t_rise) / 8.0);
                spi_miso = resp[7 - bitc];
            end
        end
        p_sck = spi_sck;
        p_cs  = spi_cs_n;
    end

    task automatic ctl(input logic go, input logic atm, input logic psel, input logic [2:0] ptr,
                       input logic den, input logic [5:0] cnt, input logic ie, input logic [2:0] rate);
        logic was_busy;
        @(negedge clk);
        was_busy = cyc_busy;
        ctl_wr = 1; ctl_go = go; ctl_atomic = atm; ctl_prefix_sel = psel; ctl_op_ptr = ptr;
        ctl_data_en = den; ctl_byte_cnt = cnt; ctl_irq_en = ie; ctl_rate = rate;
        #1;
        if (go && atm && req2 && !was_busy)
            chk(gnt2 == 1'b0, "R12 same-cycle gnt2", 64'(gnt2), 0);
        @(negedge clk);
        ctl_wr = 0; ctl_go = 0;
        if (go && !was_busy) chk(cyc_busy == 1'b1, "R5 busy after go", 64'(cyc_busy), 1);
    endtask

    task automatic wait_done();
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            if (cyc_done) return;
        end
        chk(1'b0, {cur_req, " timeout"}, 0, 1);
    endtask

    task automatic clear_done();
        @(negedge clk); done_clr = 1;
        @(negedge clk); done_clr = 0;
    endtask

    initial begin
        #1_200_000;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + mon_cmp + 1, n_bad + mon_bad);
        $finish;
    end

    initial begin
        // menu: 0 plain read(01), 1 program(11), 2 id read(00), 3 erase(11), 4 wr status(10)
        menu_opcodes = {8'h00, 8'h00, 8'h00, 8'h01, 8'h20, 8'h9F, 8'h02, 8'h03};
        menu_types   = {2'b00, 2'b00, 2'b00, 2'b10, 2'b11, 2'b00, 2'b11, 2'b01};
        for (int k = 0; k < 64; k++) wdata[k*8 +: 8] = 8'(k * 3 + 1);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        armed = 1;
        chk(cyc_busy == 0, "R5 reset busy", 64'(cyc_busy), 0);
        chk(cyc_done == 0, "R4 reset done", 64'(cyc_done), 0);
        chk(spi_cs_n == 1, "R3 reset cs_n", 64'(spi_cs_n), 1);
        req2 = 1; #1;
        chk(gnt2 == 1, "R12 idle grant", 64'(gnt2), 1);
        req2 = 0;

        // ID read, no address, 3 read bytes, fast rate
        cur_req = "R13";
        push_b(8'h9F); push_b(0); push_b(0); push_b(0); push_end();
        ctl(1, 0, 0, 3'd2, 1, 6'd2, 0, 3'b100);
        wait_done();
        chk(rdata[23:0] == 24'h434241, "R13 read capture", 64'(rdata[23:0]), 64'h434241);
        chk(last_hi == 2, "R9 fast half-period", 64'(last_hi), 2);
        chk(irq == 0, "R11 irq disabled", 64'(irq), 0);
        clear_done();
        chk(cyc_done == 0, "R11 done cleared", 64'(cyc_done), 0);

        // plain read with address, one byte, forced slow
        cur_req = "R1";
        push_b(8'h03); push_b(8'h12); push_b(8'h34); push_b(8'h56); push_b(0); push_end();
        ctl(1, 0, 0, 3'd0, 1, 6'd0, 0, 3'b100);
        wait_done();
        chk(rdata[7:0] == 8'h44, "R1 single byte read", 64'(rdata[7:0]), 64'h44);
        chk(last_hi == 5, "R9 plain read slow", 64'(last_hi), 5);
        clear_done();

        // 64-byte program
        cur_req = "R1";
        push_b(8'h02); push_b(8'h12); push_b(8'h34); push_b(8'h56);
        for (int k = 0; k < 64; k++) push_b(8'(k * 3 + 1));
        push_end();
        ctl(1, 0, 0, 3'd1, 1, 6'd63, 0, 3'b100);
        wait_done();
        chk(exp_q.size() == 0, "R1 64 bytes sent", 64'(exp_q.size()), 0);
        clear_done();

        // erase with data disabled: count ignored
        cur_req = "R2";
        push_b(8'h20); push_b(8'h12); push_b(8'h34); push_b(8'h56); push_end();
        ctl(1, 0, 0, 3'd3, 0, 6'd5, 0, 3'b100);
        wait_done();
        chk(exp_q.size() == 0, "R2 no data phase", 64'(exp_q.size()), 0);
        clear_done();

        // atomic program with prefix 0, two busy polls
        cur_req = "R3";
        busy_polls = 2; polls = 0;
        push_b(8'h06); push_end();
        push_b(8'h02); push_b(8'h12); push_b(8'h34); push_b(8'h56); push_b(8'h01); push_b(8'h04); push_end();
        for (int p = 0; p < 3; p++) begin push_b(8'h05); push_b(8'h00); push_end(); end
        req2 = 1;
        ctl(1, 1, 0, 3'd1, 1, 6'd1, 1, 3'b100);
        wait (polls == 1);
        ctl(1, 0, 0, 3'd2, 1, 6'd0, 1, 3'b100); // R6 go while busy
        wait (polls == 2);
        @(negedge clk);
        chk(cyc_busy == 1, "R4 busy while polling", 64'(cyc_busy), 1);
        chk(cyc_done == 0, "R4 done held", 64'(cyc_done), 0);
        chk(gnt2 == 0, "R12 grant blocked", 64'(gnt2), 0);
        wait_done();
        chk(polls == 3, "R3 poll count", 64'(polls), 3);
        chk(irq == 1, "R11 irq on done", 64'(irq), 1);
        chk(gnt2 == 1, "R12 grant after", 64'(gnt2), 1);
        repeat (40) @(negedge clk);
        chk(exp_q.size() == 0, "R6 no extra frame", 64'(exp_q.size()), 0);
        clear_done();
        chk(irq == 0, "R11 irq cleared", 64'(irq), 0);
        req2 = 0;

        // atomic with second prefix, no address, no data, not busy
        cur_req = "R8";
        busy_polls = 0; polls = 0;
        push_b(8'h50); push_end(); push_b(8'h01); push_end();
        push_b(8'h05); push_b(8'h00); push_end();
        ctl(1, 1, 1, 3'd4, 0, 6'd0, 0, 3'b100);
        wait_done();
        chk(exp_q.size() == 0, "R8 prefix high byte", 64'(exp_q.size()), 0);
        clear_done();

        // lock-down and same-write fields
        lock_down = 1;
        ctl(0, 0, 0, 3'd0, 0, 6'd0, 0, 3'b001);
        chk(cur_rate == 3'b100, "R10 rate locked", 64'(cur_rate), 64'h4);
        lock_down = 0;
        cur_req = "R7";
        push_b(8'h9F); push_b(0); push_end();
        ctl(1, 0, 0, 3'd2, 1, 6'd0, 0, 3'b001);
        chk(cur_rate == 3'b001, "R9 rate readback", 64'(cur_rate), 1);
        wait_done();
        chk(last_hi == 3, "R7 new rate used", 64'(last_hi), 3);
        chk(rdata[7:0] == 8'h41, "R7 new pointer used", 64'(rdata[7:0]), 64'h41);
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R7 frames consumed", 64'(exp_q.size()), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + mon_cmp, n_bad + mon_bad);
        $finish;
    end
endmodule